// File: doc/BRIEF.md
# Packet Command Task-File Front End

This block is the device side of a disk-style task-file register set, reached by a host through eight byte-wide registers and a 16-bit data port. A write to the command register starts one of four operations: packet entry, identify for packet devices, the plain disk identify (always refused), or set-features. During packet entry the host writes six 16-bit words. The block gathers the resulting 12-byte command and passes it to a media back-end as a one-cycle valid pulse.

The back-end replies with a total length or an error. The block then serves the response to the host as 16-bit words, fetching one word from the back-end for each host word read. A long response is cut into chunks of at most `MAX_CHUNK` bytes. The byte-count registers are reloaded before each chunk, and an interrupt is raised at every phase change. Any byte read of a register clears the interrupt.

States: `ST_IDLE` (no transfer), `ST_PACKET` (gathering command words), `ST_AWAIT` (waiting for the back-end reply), `ST_STREAM` (serving back-end words) and `ST_IDENT` (serving the built-in identify block). Transitions:
- Any state goes to `ST_PACKET` on command 0xA0, to `ST_IDENT` on 0xA1, and to `ST_IDLE` on 0xEC or 0xEF.
- `ST_PACKET` goes to `ST_AWAIT` on the sixth word write.
- `ST_AWAIT` goes to `ST_STREAM` on a good reply with a non-zero length, and to `ST_IDLE` on an error or a zero length.
- `ST_STREAM` goes to `ST_IDLE` when the last chunk is drained.
- `ST_IDENT` goes to `ST_IDLE` after 512 bytes.

Top module: `pktfe_top`

## Requirements
- R1: After reset, status (offset 7) reads 0x00, error (offset 1) reads 0x01, count low (offset 4) reads 0x14, count high (offset 5) reads 0xEB, and `irq_o` is low.
- R2: Byte writes to offsets 1 to 6 are read back unchanged at the same offset. A byte read of offset 0 returns 0.
- R3: Command 0xA0 sets status to 0x08 (data request) and interrupt reason (offset 2) to 0x01 (command phase), without raising the interrupt. The sixth following word write produces a one-cycle `be_cmd_valid` carrying the 12 bytes, with packet byte 2k equal to the low byte of word k.
- R4: A good reply of length L > 0 sets the count registers to min(L, 63488), status to 0x18 (data request 0x08 | service 0x10) and interrupt reason to 0x02 (IO), and raises `irq_o`.
- R5: A good reply of length 0 sets status to 0x40 (ready), interrupt reason to 0x03 and count to 0, and raises `irq_o`.
- R6: Each word read during a transfer returns the back-end word and pulses `be_word_rd`; a chunk ends after ceil(chunk/2) reads. If bytes remain, the count is reloaded with the next chunk and `irq_o` rises. After the last chunk, status becomes 0x00, interrupt reason 0x02, and `irq_o` rises.
- R7: An error reply sets status to 0x09 (data request | check), error to 0x50 and count to 0, and does not raise `irq_o`.
- R8: Command 0xEC sets error to 0x04 and status to 0x01, and raises `irq_o`.
- R9: Command 0xEF sets status to 0x00, abandons any transfer in progress and raises `irq_o`.
- R10: Command 0xA1 sets count to 0x0200 and status to 0x08, and raises `irq_o`. Its 256 words are 0x8580 at word 0, 0x0600 at word 49 and 0 elsewhere. After them, status is 0x00, interrupt reason is 0x02 and `irq_o` rises.
- R11: Any byte read of a register clears `irq_o` on the next cycle.
- R12: A word read outside a transfer returns 0 and does not pulse `be_word_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_wr | input | 1 | Byte register write strobe |
| hp_rd | input | 1 | Byte register read strobe |
| hp_addr | input | 3 | Register offset |
| hp_wdata | input | 8 | Byte write data |
| hp_rdata | output | 8 | Byte read data (combinational) |
| hp_wwr | input | 1 | 16-bit data port write strobe |
| hp_wdata16 | input | 16 | Data port write word |
| hp_wrd | input | 1 | 16-bit data port read strobe |
| hp_rdata16 | output | 16 | Data port read word (combinational) |
| irq_o | output | 1 | Interrupt to host |
| be_cmd_valid | output | 1 | Packet handed to back-end |
| be_cmd_pkt | output | 96 | Packet bytes, byte i at bits 8i+7:8i |
| be_rsp_valid | input | 1 | Back-end reply strobe |
| be_rsp_err | input | 1 | Reply is an error |
| be_rsp_len | input | 24 | Reply length in bytes |
| be_word_rd | output | 1 | Consume current back-end word |
| be_word_in | input | 16 | Current back-end word |

## Verification
The hardest situation to reach is the chunk boundary of a long response. Reaching it needs a reply longer than 63488 bytes and more than 31,000 consecutive host word reads before the count reload and the second interrupt appear. The bench drives a directed reply of 63494 bytes and one of exactly 63488 bytes, reading every word back-to-back at one word per cycle. Constrained-random packets with short, often odd, lengths cover the end-of-transfer rounding.

// File: rtl/pktfe_pkg.sv
package pktfe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_PACKET, ST_AWAIT, ST_STREAM, ST_IDENT
    } fe_state_t;

    localparam logic [7:0] STS_READY = 8'h40;
    localparam logic [7:0] STS_SERV  = 8'h10;
    localparam logic [7:0] STS_DRQ   = 8'h08;
    localparam logic [7:0] STS_CHK   = 8'h01;

    localparam logic [7:0] IR_COD = 8'h01;
    localparam logic [7:0] IR_IO  = 8'h02;

    localparam logic [7:0] OP_PACKET  = 8'hA0;
    localparam logic [7:0] OP_IDPKT   = 8'hA1;
    localparam logic [7:0] OP_IDDISK  = 8'hEC;
    localparam logic [7:0] OP_SETFEAT = 8'hEF;

    localparam logic [2:0] TF_DATA = 3'd0;
    localparam logic [2:0] TF_ERR  = 3'd1;
    localparam logic [2:0] TF_IRSN = 3'd2;
    localparam logic [2:0] TF_TAG  = 3'd3;
    localparam logic [2:0] TF_CLO  = 3'd4;
    localparam logic [2:0] TF_CHI  = 3'd5;
    localparam logic [2:0] TF_DSEL = 3'd6;
    localparam logic [2:0] TF_CMD  = 3'd7;
endpackage

// File: rtl/pktfe_ident.sv
module pktfe_ident #(
    parameter logic [15:0] WORD0    = 16'h8580,
    parameter int          CAP_IDX  = 49,
    parameter logic [15:0] CAP_WORD = 16'h0600
) (
    input  logic [7:0]  widx,
    output logic [15:0] word
);
    always_comb begin
        if (widx == 8'd0)                 word = WORD0;
        else if (widx == 8'(CAP_IDX))     word = CAP_WORD;
        else                              word = 16'h0000;
    end
endmodule

// File: rtl/pktfe_split.sv
module pktfe_split #(
    parameter int LEN_W     = 24,
    parameter int MAX_CHUNK = 63488
) (
    input  logic [LEN_W-1:0] total,
    output logic [LEN_W-1:0] chunk,
    output logic [LEN_W-1:0] rest
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_CHUNK);

    always_comb begin
        chunk = (total > LIMIT) ? LIMIT : total;
        rest  = total - chunk;
    end
endmodule

// File: rtl/pktfe_top.sv
module pktfe_top
    import pktfe_pkg::*;
#(
    parameter int LEN_W     = 24,
    parameter int MAX_CHUNK = 63488,
    parameter int PKT_BYTES = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hp_wr,
    input  logic                   hp_rd,
    input  logic [2:0]             hp_addr,
    input  logic [7:0]             hp_wdata,
    output logic [7:0]             hp_rdata,
    input  logic                   hp_wwr,
    input  logic [15:0]            hp_wdata16,
    input  logic                   hp_wrd,
    output logic [15:0]            hp_rdata16,
    output logic                   irq_o,
    output logic                   be_cmd_valid,
    output logic [PKT_BYTES*8-1:0] be_cmd_pkt,
    input  logic                   be_rsp_valid,
    input  logic                   be_rsp_err,
    input  logic [LEN_W-1:0]       be_rsp_len,
    output logic                   be_word_rd,
    input  logic [15:0]            be_word_in
);
    localparam logic [LEN_W-1:0] PKT_LAST = LEN_W'(PKT_BYTES - 2);
    localparam logic [LEN_W-1:0] ID_LEN   = LEN_W'(512);

    fe_state_t state, state_nxt;
    logic [7:0] sts_q, err_q, ir_q, tag_q, clo_q, chi_q, dsel_q;
    logic [LEN_W-1:0] ptr, cur_len, remain, split_src, chunk, rest, ptr_next;
    logic [PKT_BYTES*8-1:0] pkt_q;
    logic cmd_wr, pkt_last, rd_fire, chunk_end, cmdv_q, irq_q;
    logic [15:0] id_word;

    assign cmd_wr    = hp_wr && (hp_addr == TF_CMD);
    assign pkt_last  = (state == ST_PACKET) && hp_wwr && (ptr == PKT_LAST);
    assign rd_fire   = hp_wrd && ((state == ST_STREAM) || (state == ST_IDENT));
    assign ptr_next  = ptr + LEN_W'(2);
    assign chunk_end = rd_fire && (ptr_next >= cur_len);
    assign split_src = (state == ST_AWAIT) ? be_rsp_len : remain;

    pktfe_split #(.LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK)) split_i (
        .total(split_src), .chunk(chunk), .rest(rest)
    );

    pktfe_ident ident_i (.widx(ptr[8:1]), .word(id_word));

    // next-state decision
    always_comb begin
        state_nxt = state;
        if (cmd_wr) begin
            unique case (hp_wdata)
                OP_PACKET:             state_nxt = ST_PACKET;
                OP_IDPKT:              state_nxt = ST_IDENT;
                OP_IDDISK, OP_SETFEAT: state_nxt = ST_IDLE;
                default:               state_nxt = state;
            endcase
        end else begin
            unique case (state)
                ST_IDLE:   state_nxt = ST_IDLE;
                ST_PACKET: if (pkt_last) state_nxt = ST_AWAIT;
                ST_AWAIT:  if (be_rsp_valid)
                               state_nxt = (be_rsp_err || be_rsp_len == '0) ? ST_IDLE : ST_STREAM;
                ST_STREAM: if (chunk_end && remain == '0) state_nxt = ST_IDLE;
                ST_IDENT:  if (chunk_end) state_nxt = ST_IDLE;
                default:   state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // registers and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 8'h00; err_q <= 8'h01; ir_q <= 8'h00; tag_q <= 8'h00;
            clo_q <= 8'h14; chi_q <= 8'hEB; dsel_q <= 8'h00;
            ptr <= '0; cur_len <= '0; remain <= '0; pkt_q <= '0;
            cmdv_q <= 1'b0; irq_q <= 1'b0;
        end else begin
            cmdv_q <= 1'b0;
            if (hp_rd) irq_q <= 1'b0;
            if (hp_wr) begin
                unique case (hp_addr)
                    TF_ERR:  err_q  <= hp_wdata;
                    TF_IRSN: ir_q   <= hp_wdata;
                    TF_TAG:  tag_q  <= hp_wdata;
                    TF_CLO:  clo_q  <= hp_wdata;
                    TF_CHI:  chi_q  <= hp_wdata;
                    TF_DSEL: dsel_q <= hp_wdata;
                    default: ;
                endcase
            end
            if (cmd_wr) begin
                unique case (hp_wdata)
                    OP_PACKET: begin
                        sts_q <= STS_DRQ; ir_q <= IR_COD;
                        ptr <= '0; cur_len <= '0; remain <= '0;
                    end
                    OP_IDPKT: begin
                        sts_q <= STS_DRQ; ptr <= '0; cur_len <= ID_LEN; remain <= '0;
                        {chi_q, clo_q} <= 16'h0200; irq_q <= 1'b1;
                    end
                    OP_IDDISK: begin
                        err_q <= 8'h04; sts_q <= STS_CHK; irq_q <= 1'b1;
                    end
                    OP_SETFEAT: begin
                        sts_q <= 8'h00; ptr <= '0; cur_len <= '0; remain <= '0;
                        irq_q <= 1'b1;
                    end
                    default: ;
                endcase
            end else begin
                unique case (state)
                    ST_PACKET: if (hp_wwr) begin
                        pkt_q[{ptr[3:1], 4'b0000} +: 16] <= hp_wdata16;
                        if (pkt_last) begin
                            ptr <= '0; cmdv_q <= 1'b1;
                        end else begin
                            ptr <= ptr_next;
                        end
                    end
                    ST_AWAIT: if (be_rsp_valid) begin
                        if (be_rsp_err) begin
                            sts_q <= STS_DRQ | STS_CHK; err_q <= 8'h50;
                            {chi_q, clo_q} <= 16'h0000;
                        end else if (be_rsp_len == '0) begin
                            sts_q <= STS_READY; ir_q <= IR_IO | IR_COD;
                            {chi_q, clo_q} <= 16'h0000; irq_q <= 1'b1;
                        end else begin
                            sts_q <= STS_DRQ | STS_SERV; ir_q <= IR_IO;
                            {chi_q, clo_q} <= chunk[15:0];
                            cur_len <= chunk; remain <= rest; ptr <= '0;
                            irq_q <= 1'b1;
                        end
                    end
                    ST_STREAM, ST_IDENT: if (rd_fire) begin
                        if (chunk_end) begin
                            ptr <= '0; irq_q <= 1'b1;
                            if (state == ST_STREAM && remain != '0) begin
                                {chi_q, clo_q} <= chunk[15:0];
                                cur_len <= chunk; remain <= rest;
                            end else begin
                                sts_q <= 8'h00; ir_q <= IR_IO;
                            end
                        end else begin
                            ptr <= ptr_next;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (hp_addr)
            TF_DATA: hp_rdata = 8'h00;
            TF_ERR:  hp_rdata = err_q;
            TF_IRSN: hp_rdata = ir_q;
            TF_TAG:  hp_rdata = tag_q;
            TF_CLO:  hp_rdata = clo_q;
            TF_CHI:  hp_rdata = chi_q;
            TF_DSEL: hp_rdata = dsel_q;
            default: hp_rdata = sts_q;
        endcase
    end

    assign hp_rdata16   = (state == ST_STREAM) ? be_word_in :
                          (state == ST_IDENT)  ? id_word : 16'h0000;
    assign be_word_rd   = hp_wrd && (state == ST_STREAM);
    assign be_cmd_valid = cmdv_q;
    assign be_cmd_pkt   = pkt_q;
    assign irq_o        = irq_q;

    // R3
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_cmd_valid |=> !be_cmd_valid);
    // R4
    chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'({chi_q, clo_q}) <= 32'(MAX_CHUNK) || hp_wr);
    // R6
    stream_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM) |-> (sts_q == (STS_DRQ | STS_SERV)));
    // R11
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_rd && !hp_wr && !hp_wwr && !hp_wrd && !be_rsp_valid) |=> !irq_o);
endmodule

// File: tb/pktfe_top_tb_top.sv
module pktfe_top_tb_top;
    localparam int MAXC = 63488;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hp_wr = 0, hp_rd = 0, hp_wwr = 0, hp_wrd = 0;
    logic [2:0] hp_addr = 0;
    logic [7:0] hp_wdata = 0, hp_rdata;
    logic [15:0] hp_wdata16 = 0, hp_rdata16, be_word_in;
    logic irq_o, be_cmd_valid, be_word_rd;
    logic [95:0] be_cmd_pkt;
    logic be_rsp_valid = 0, be_rsp_err = 0;
    logic [23:0] be_rsp_len = 0;
    int errors = 0, checks = 0, widx = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pktfe_top dut_i (
        .clk(clk), .rst_n(rst_n), .hp_wr(hp_wr), .hp_rd(hp_rd), .hp_addr(hp_addr),
        .hp_wdata(hp_wdata), .hp_rdata(hp_rdata), .hp_wwr(hp_wwr), .hp_wdata16(hp_wdata16),
        .hp_wrd(hp_wrd), .hp_rdata16(hp_rdata16), .irq_o(irq_o), .be_cmd_valid(be_cmd_valid),
        .be_cmd_pkt(be_cmd_pkt), .be_rsp_valid(be_rsp_valid), .be_rsp_err(be_rsp_err),
        .be_rsp_len(be_rsp_len), .be_word_rd(be_word_rd), .be_word_in(be_word_in)
    );

    function automatic logic [15:0] pat(int k);
        return 16'(k * 40503) ^ 16'h1234;
    endfunction
    function automatic logic [15:0] ident_exp(int k);
        return (k == 0) ? 16'h8580 : (k == 49) ? 16'h0600 : 16'h0000;
    endfunction

    assign be_word_in = pat(widx);
    always @(posedge clk) if (be_word_rd) widx <= widx + 1;

    task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); hp_wr = 1; hp_addr = a; hp_wdata = d;
        @(posedge clk); #1 hp_wr = 0;
    endtask
    task automatic brd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk); hp_rd = 1; hp_addr = a; #1 d = hp_rdata;
        @(posedge clk); #1 hp_rd = 0;
    endtask
    task automatic wwr(logic [15:0] w);
        @(negedge clk); hp_wwr = 1; hp_wdata16 = w;
        @(posedge clk); #1 hp_wwr = 0;
    endtask
    task automatic wrd(output logic [15:0] w, output logic f);
        @(negedge clk); hp_wrd = 1; #1 w = hp_rdata16; f = be_word_rd;
        @(posedge clk); #1 hp_wrd = 0;
    endtask
    task automatic respond(logic e, logic [23:0] l);
        @(negedge clk); be_rsp_valid = 1; be_rsp_err = e; be_rsp_len = l;
        @(posedge clk); #1 be_rsp_valid = 0;
    endtask

    task automatic count_is(string req, logic [15:0] exp);
        logic [7:0] lo, hi;
        brd(3'd4, lo); brd(3'd5, hi);
        chk(req, {hi, lo}, exp);
    endtask

    // one packet command with a good reply of len bytes, drained to the end
    task automatic run_packet(int len);
        logic [95:0] pkt;
        logic [7:0] b;
        logic [15:0] w;
        logic f;
        int rem, bad, k;
        bwr(3'd7, 8'h00 + 8'hA0);
        brd(3'd7, b); chk("R3 status", b, 8'h08);
        brd(3'd2, b); chk("R3 reason", b, 8'h01);
        chk("R3 no irq", irq_o, 0);
        for (int i = 0; i < 6; i++) begin
            w = 16'($urandom);
            pkt[16*i +: 16] = w;
            wwr(w);
            if (i < 5) chk("R3 early", be_cmd_valid, 0);
        end
        chk("R3 valid", be_cmd_valid, 1);
        chk("R3 bytes", be_cmd_pkt, pkt);
        respond(0, 24'(len));
        if (len == 0) begin
            chk("R5 irq", irq_o, 1);
            brd(3'd7, b); chk("R5 status", b, 8'h40);
            brd(3'd2, b); chk("R5 reason", b, 8'h03);
            count_is("R5 count", 16'h0000);
            return;
        end
        rem = len;
        k = widx;
        while (rem > 0) begin
            int c = (rem > MAXC) ? MAXC : rem;
            rem -= c;
            chk("R4 irq", irq_o, 1);
            brd(3'd7, b); chk("R4 status", b, 8'h18);
            brd(3'd2, b); chk("R4 reason", b, 8'h02);
            count_is("R4 count", 16'(c));
            bad = 0;
            for (int j = 0; j < (c + 1) / 2; j++) begin
                wrd(w, f);
                if (w !== pat(k) || f !== 1'b1) bad++;
                k++;
            end
            chk("R6 words", bad, 0);
        end
        chk("R6 end irq", irq_o, 1);
        brd(3'd7, b); chk("R6 end status", b, 8'h00);
        brd(3'd2, b); chk("R6 end reason", b, 8'h02);
    endtask

    initial begin
        logic [7:0] b;
        logic [15:0] w;
        logic f;
        int bad, seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset
        chk("R1 irq", irq_o, 0);
        brd(3'd7, b); chk("R1 status", b, 8'h00);
        brd(3'd1, b); chk("R1 error", b, 8'h01);
        count_is("R1 signature", 16'hEB14);
        // R2 register read-back
        for (int a = 1; a <= 6; a++) begin
            logic [7:0] v = 8'($urandom);
            bwr(3'(a), v); brd(3'(a), b); chk("R2 readback", b, v);
        end
        brd(3'd0, b); chk("R2 data byte", b, 8'h00);
        // R12 word read while idle
        wrd(w, f); chk("R12 data", w, 16'h0000); chk("R12 no fetch", f, 0);
        // R8 plain identify refused
        bwr(3'd7, 8'hEC);
        chk("R8 irq", irq_o, 1);
        brd(3'd1, b); chk("R8 error", b, 8'h04);
        brd(3'd7, b); chk("R8 status", b, 8'h01);
        // R11 irq cleared by byte read
        bwr(3'd7, 8'hEF);
        chk("R9 irq", irq_o, 1);
        brd(3'd2, b); chk("R11 cleared", irq_o, 0);
        // R10 identify block
        bwr(3'd7, 8'hA1);
        chk("R10 irq", irq_o, 1);
        brd(3'd7, b); chk("R10 status", b, 8'h08);
        count_is("R10 count", 16'h0200);
        bad = 0;
        for (int j = 0; j < 256; j++) begin
            wrd(w, f);
            if (w !== ident_exp(j) || f !== 1'b0) bad++;
        end
        chk("R10 words", bad, 0);
        chk("R10 end irq", irq_o, 1);
        brd(3'd7, b); chk("R10 end status", b, 8'h00);
        brd(3'd2, b); chk("R10 end reason", b, 8'h02);
        // R5 zero length, then random short lengths
        run_packet(0);
        for (int r = 0; r < 6; r++) run_packet(1 + int'($urandom % 300));
        // R7 error reply
        bwr(3'd7, 8'hA0);
        for (int i = 0; i < 6; i++) wwr(16'($urandom));
        brd(3'd7, b);
        respond(1, 24'd100);
        chk("R7 irq", irq_o, 0);
        brd(3'd7, b); chk("R7 status", b, 8'h09);
        brd(3'd1, b); chk("R7 error", b, 8'h50);
        count_is("R7 count", 16'h0000);
        // R9 set-features abandons a stream
        bwr(3'd7, 8'hA0);
        for (int i = 0; i < 6; i++) wwr(16'($urandom));
        respond(0, 24'd40);
        for (int j = 0; j < 3; j++) wrd(w, f);
        brd(3'd7, b);
        bwr(3'd7, 8'hEF);
        chk("R9 irq", irq_o, 1);
        brd(3'd7, b); chk("R9 status", b, 8'h00);
        wrd(w, f); chk("R9 stopped", {w, 7'd0, f}, 24'h0);
        // R4/R6 chunk boundaries
        run_packet(MAXC);
        run_packet(MAXC + 6);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule